// File: doc/BRIEF.md
# Parallel Bit Deposit and Extract Unit

This execution unit performs two mask-driven bit permutations on a 32- or 64-bit operand. In deposit mode the low-order bits of the source are scattered, in order, to the positions where the mask holds a one. In extract mode the source bits found under the mask's ones are gathered, in order, into the low-order bits of the result. Every result bit not written by a step is zero.

The unit is serial. One set mask bit is consumed per clock: the lowest remaining one is isolated, used, and then removed from the working mask. The operation ends when the working mask is empty. A request is offered with `start` while the unit is idle. `busy` covers the iteration, and `done` pulses for one cycle when `result` and `illegal` are valid.

Three qualification inputs gate each request: a feature enable, a prefix-present flag and a vector-length field. If the request fails qualification, no iteration is run and the unit reports an illegal operation instead.

Top module: `pdx_unit`

## Requirements
- R1: After reset, `busy`, `done` and `illegal` are 0 and `result` is all zeros.
- R2: Deposit (`op`=0): for each k, source bit k is written to the position of the k-th lowest set bit of the effective mask.
- R3: Extract (`op`=1): the source bit at the position of the k-th lowest set bit of the effective mask is written to result bit k.
- R4: Result bits not written by any step are 0. A zero effective mask gives a zero result, with `done` high in the cycle after the start cycle.
- R5: With `size64`=0 the effective mask is the low 32 mask bits zero-extended, so result bits 63..32 are 0. With `size64`=1 all 64 mask bits are used.
- R6: A request is illegal when `feat_en`=0, `prefix_ok`=0 or `vlen`≠0. It then pulses `done` in the next cycle with `illegal`=1 and `result`=0, and `busy` stays low.
- R7: For a legal request whose effective mask has p ones, `done` is high in cycle p+1, counting the start cycle as cycle 0. For p>0, `busy` is high from cycle 1 until `done` rises and is low while `done` is high.
- R8: A `start` presented while `busy` is high is ignored. It changes neither the result nor the timing of the operation in progress.
- R9: `done` lasts one cycle per accepted request. `result` and `illegal` hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request an operation; accepted only when `busy` is low |
| op | input | 1 | 0 = deposit, 1 = extract |
| size64 | input | 1 | 1 = 64-bit operands, 0 = 32-bit |
| src | input | W (64) | Source operand |
| mask | input | W (64) | Selection mask |
| feat_en | input | 1 | Feature enable qualification |
| prefix_ok | input | 1 | Required prefix was present |
| vlen | input | VLW (2) | Vector-length field; must be zero |
| busy | output | 1 | Iteration in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Last request failed qualification |
| result | output | W (64) | Operation result |

## Verification
A bad step counter or working mask shows up as misplaced or missing result bits as soon as `done` rises. A mask that loses or keeps an extra bit shows up as `done` arriving one or more cycles away from popcount+1. A bad qualification decode shows up in the cycle after `start` as a wrong `illegal` flag, a nonzero result, or a `busy` that should not be there. Stray acceptance of a `start` during `busy` corrupts the running result or shifts its `done` cycle, and a broken 32-bit zero-extension shows up as nonzero upper result bits.

// File: rtl/pdx_unit.sv
module pdx_unit #(
  parameter int W   = 64,
  parameter int VLW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           op,
  input  logic           size64,
  input  logic [W-1:0]   src,
  input  logic [W-1:0]   mask,
  input  logic           feat_en,
  input  logic           prefix_ok,
  input  logic [VLW-1:0] vlen,
  output logic           busy,
  output logic           done,
  output logic           illegal,
  output logic [W-1:0]   result
);
  localparam int HW = W / 2;
  localparam int KW = $clog2(W);

  logic          op_r, size_r;
  logic [W-1:0]  src_r, mask_r;
  logic [KW-1:0] k_r;

  wire          bad      = !feat_en || !prefix_ok || (vlen != '0);
  wire [W-1:0]  eff_mask = size64 ? mask : {{HW{1'b0}}, mask[HW-1:0]};
  wire [W-1:0]  low_bit  = mask_r & (~mask_r + 1'b1);
  wire [W-1:0]  rest     = mask_r & (mask_r - 1'b1);
  wire          src_at   = |(src_r & low_bit);
  wire [W-1:0]  ext_bit  = {{(W-1){1'b0}}, src_at} << k_r;
  wire [W-1:0]  step_bits = op_r ? ext_bit : (src_r[k_r] ? low_bit : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
      result  <= '0;
      op_r    <= 1'b0;
      size_r  <= 1'b0;
      src_r   <= '0;
      mask_r  <= '0;
      k_r     <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        illegal <= bad;
        result  <= '0;
        op_r    <= op;
        size_r  <= size64;
        src_r   <= src;
        k_r     <= '0;
        if (bad) begin
          mask_r <= '0;
          done   <= 1'b1;
        end else begin
          mask_r <= eff_mask;
          busy   <= (eff_mask != '0);
          done   <= (eff_mask == '0);
        end
      end else if (busy) begin
        result <= result | step_bits;
        mask_r <= rest;
        k_r    <= k_r + 1'b1;
        if (rest == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R6
  illegal_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (result == '0 && !busy));

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R2 R3: each busy cycle consumes exactly one mask bit
  one_bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($countones(mask_r) + 1 == $countones($past(mask_r))));

  // R5
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !size_r) |-> (result[W-1:HW] == '0));

  // R8
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

// File: tb/tb_pdx_unit.sv
module tb_pdx_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op = 1'b0, size64 = 1'b1;
  logic [63:0] src = '0, mask = '0;
  logic        feat_en = 1'b1, prefix_ok = 1'b1;
  logic [1:0]  vlen = '0;
  logic        busy, done, illegal;
  logic [63:0] result;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pdx_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .size64(size64),
    .src(src), .mask(mask), .feat_en(feat_en), .prefix_ok(prefix_ok),
    .vlen(vlen), .busy(busy), .done(done), .illegal(illegal), .result(result)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_dep(input logic [63:0] s, input logic [63:0] m);
    logic [63:0] r = '0;
    int j = 0;
    for (int i = 0; i < 64; i++) if (m[i]) begin r[i] = s[j]; j++; end
    return r;
  endfunction

  function automatic logic [63:0] ref_ext(input logic [63:0] s, input logic [63:0] m);
    logic [63:0] r = '0;
    int j = 0;
    for (int i = 0; i < 64; i++) if (m[i]) begin r[j] = s[i]; j++; end
    return r;
  endfunction

  // Issue one request; optionally pulse a stray start while busy (R8)
  task automatic run_op(input logic o, input logic s64, input logic [63:0] s,
                        input logic [63:0] m, input logic fe, input logic po,
                        input logic [1:0] vl, input bit stray, input string req);
    logic [63:0] em, exp_res, held;
    bit bad;
    int p, n, exp_n;
    em  = s64 ? m : {32'h0, m[31:0]};
    bad = !fe || !po || (vl != 2'b00);
    p   = $countones(em);
    exp_res = bad ? 64'h0 : (o ? ref_ext(s, em) : ref_dep(s, em));
    exp_n   = bad ? 1 : p + 1;
    @(negedge clk);
    start = 1'b1; op = o; size64 = s64; src = s; mask = m;
    feat_en = fe; prefix_ok = po; vlen = vl;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 300) begin
      if (n == 1) chk(busy == 1'b1, "R7", "busy during iteration", 64'(busy), 64'h1);
      if (stray && n == 3) begin
        start = 1'b1; op = ~o; src = ~s; mask = 64'h1; size64 = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(n == exp_n, bad ? "R6" : "R7", {req, " done cycle"}, 64'(n), 64'(exp_n));
    chk(illegal == bad, "R6", {req, " illegal flag"}, 64'(illegal), 64'(bad));
    chk(result == exp_res, req, {req, " result"}, result, exp_res);
    chk(busy == 1'b0, "R7", {req, " busy low at done"}, 64'(busy), 64'h0);
    held = result;
    @(negedge clk);
    chk(done == 1'b0, "R9", {req, " single done"}, 64'(done), 64'h0);
    @(negedge clk);
    chk(result == held && illegal == bad, "R9", {req, " hold"}, result, held);
  endtask

  task automatic t_reset();
    chk(busy == 0 && done == 0 && illegal == 0, "R1", "reset flags",
        {61'h0, busy, done, illegal}, 64'h0);
    chk(result == 64'h0, "R1", "reset result", result, 64'h0);
  endtask

  task automatic t_zero_mask();
    run_op(1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1, 1, 2'b00, 0, "R4");
    run_op(1'b1, 1'b1, 64'hDEAD_BEEF_1234_5678, 64'h0, 1, 1, 2'b00, 0, "R4");
  endtask

  task automatic t_all_ones();
    run_op(1'b0, 1'b1, 64'h0123_4567_89AB_CDEF, '1, 1, 1, 2'b00, 0, "R2");
    run_op(1'b1, 1'b1, 64'hFEDC_BA98_7654_3210, '1, 1, 1, 2'b00, 0, "R3");
  endtask

  task automatic t_single_bits();
    run_op(1'b0, 1'b1, 64'h1, 64'h1, 1, 1, 2'b00, 0, "R2");
    run_op(1'b0, 1'b1, 64'h1, 64'h8000_0000_0000_0000, 1, 1, 2'b00, 0, "R2");
    run_op(1'b1, 1'b1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1, 1, 2'b00, 0, "R3");
    run_op(1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, 64'h1, 1, 1, 2'b00, 0, "R4");
    run_op(1'b1, 1'b0, '1, 64'h0000_0000_8000_0000, 1, 1, 2'b00, 0, "R5");
  endtask

  task automatic t_size32();
    run_op(1'b0, 1'b0, '1, '1, 1, 1, 2'b00, 0, "R5");
    run_op(1'b1, 1'b0, '1, 64'hFFFF_0000_0000_00F0, 1, 1, 2'b00, 0, "R5");
    run_op(1'b1, 1'b0, '1, 64'hFFFF_FFFF_0000_0000, 1, 1, 2'b00, 0, "R5");
  endtask

  task automatic t_random();
    for (int i = 0; i < 24; i++) begin
      logic [63:0] s, m;
      s = {$urandom, $urandom};
      m = {$urandom, $urandom};
      run_op(i[0], i[1], s, m, 1, 1, 2'b00, 0, i[0] ? "R3" : "R2");
    end
  endtask

  task automatic t_illegal();
    run_op(1'b0, 1'b1, '1, '1, 0, 1, 2'b00, 0, "R6");
    run_op(1'b1, 1'b1, '1, '1, 1, 0, 2'b00, 0, "R6");
    run_op(1'b0, 1'b0, '1, '1, 1, 1, 2'b01, 0, "R6");
    run_op(1'b1, 1'b1, '1, '1, 1, 1, 2'b10, 0, "R6");
    run_op(1'b1, 1'b1, 64'h5, 64'h7, 1, 1, 2'b00, 0, "R9");
  endtask

  task automatic t_start_while_busy();
    run_op(1'b0, 1'b1, 64'hA5A5_5A5A_0F0F_F0F0, 64'hFFFF_0000_FFFF_0000, 1, 1, 2'b00, 1, "R8");
    run_op(1'b1, 1'b1, 64'h1357_9BDF_2468_ACE0, '1, 1, 1, 2'b00, 1, "R8");
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_zero_mask();
    t_all_ones();
    t_single_bits();
    t_size32();
    t_random();
    t_illegal();
    t_start_while_busy();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule